// File: doc/BRIEF.md
# Capture Configuration Decoder and Sample Strobe Generator

This block sits behind the host command path of a multi-channel capture engine. It receives short configuration commands as a byte stream. The first byte of each command is flagged by a frame-start input. The block decodes register writes and register reads, and it holds the capture settings: a 16-bit channel-enable mask, a clock divider and a base-clock select.

A read command produces one response byte. The channel mask is driven straight to the sample packer. The block also produces a one-cycle sample strobe. The strobe is derived from one of two base-clock enables, chosen by the select register and divided by (N+1), where N is the divider register. A base rate of 100 MHz with N = 0xC7 gives 500 kHz. A base rate of 160 MHz with N = 0x13 gives 8 MHz.

Top module: `cfg_rate_ctrl`

## Requirements
- R1: A write command is the four bytes 0x80, 0x01, address, data. The first byte carries frame_start. Writing address 0x02 sets chan_mask[7:0] and writing 0x03 sets chan_mask[15:8]. The new mask is visible on the cycle after the data byte.
- R2: A read command is the three bytes 0x81, 0x01, address. It yields exactly one rd_valid pulse, on the cycle after the address byte, with rd_data equal to the addressed register.
- R3: After reset the registers read back as follows: mask 0xFFFF, divider (address 0x04) 0x00, base select (address 0x0A) 0x00. With these values the strobe fires on every base_en_a tick. rd_valid and sample_stb are low during reset.
- R4: With divider N, sample_stb is high for one cycle after every (N+1)-th tick of the selected base enable. It is never high unless a base enable was high in the cycle before.
- R5: Bit 0 of register 0x0A selects the base: 0 selects base_en_a and 1 selects base_en_b. The other data bits are dropped, so the register reads back 0x00 or 0x01.
- R6: A frame whose first byte is neither 0x80 nor 0x81, or whose second byte is not 0x01, is discarded. No register changes, no response is produced, and bytes without frame_start are ignored until the next frame start.
- R7: A byte with frame_start always begins a new command, even if it arrives in the middle of an unfinished one.
- R8: Reading an address other than 0x02, 0x03, 0x04 or 0x0A returns 0x00. Writing such an address changes no register.
- R9: A new divider value or base select takes effect only at the next strobe. The period in progress completes with the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | Command byte present this cycle |
| byte_data | input | 8 | Command byte |
| frame_start | input | 1 | Marks the first byte of a command |
| base_en_a | input | 1 | Tick enable of the 100 MHz base |
| base_en_b | input | 1 | Tick enable of the 160 MHz base |
| rd_valid | output | 1 | Read response valid (one cycle) |
| rd_data | output | 8 | Read response byte |
| chan_mask | output | 16 | Channel-enable mask |
| sample_stb | output | 1 | One-cycle sample strobe |

## Verification
The assertions assume three things about the inputs. Reset is applied from the first clock edge. Every base-enable tick is a single-cycle level sampled at the edge. Command bytes arrive only with byte_valid high, so a mask change or a read response can always be traced to a byte accepted in the cycle before.

The stimulus changes inputs only on the falling edge. It holds byte_valid low between commands. It drives base_en_b as a strict alternating pattern, so tick counts map exactly onto clock cycles. Divider and select changes are issued only once the strobe period has settled.

// File: rtl/cfgrate_pkg.sv
package cfgrate_pkg;
  localparam logic [7:0] OP_WRITE    = 8'h80;
  localparam logic [7:0] OP_READ     = 8'h81;
  localparam logic [7:0] KEY_BYTE    = 8'h01;
  localparam logic [7:0] ADR_MASK_LO = 8'h02;
  localparam logic [7:0] ADR_MASK_HI = 8'h03;
  localparam logic [7:0] ADR_DIV     = 8'h04;
  localparam logic [7:0] ADR_BASE    = 8'h0A;

  typedef enum logic [1:0] {PS_IDLE, PS_KEY, PS_ADDR, PS_DATA} parse_st_t;
endpackage

// File: rtl/cmd_parser.sv
module cmd_parser
  import cfgrate_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              frame_start,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_stb,
  output logic [BYTE_W-1:0] rd_addr
);
  parse_st_t         st_q;
  logic              is_wr_q;
  logic [BYTE_W-1:0] addr_q;
  logic              cont;

  // a byte that continues an open command
  assign cont    = byte_valid && !frame_start;
  assign wr_stb  = cont && (st_q == PS_DATA);
  assign wr_addr = addr_q;
  assign wr_data = byte_data;
  assign rd_stb  = cont && (st_q == PS_ADDR) && !is_wr_q;
  assign rd_addr = byte_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= PS_IDLE;
      is_wr_q <= 1'b0;
      addr_q  <= '0;
    end else if (byte_valid) begin
      if (frame_start) begin
        is_wr_q <= (byte_data == OP_WRITE);
        if (byte_data == OP_WRITE || byte_data == OP_READ) st_q <= PS_KEY;
        else                                               st_q <= PS_IDLE;
      end else begin
        unique case (st_q)
          PS_IDLE: st_q <= PS_IDLE;
          PS_KEY:  st_q <= (byte_data == KEY_BYTE) ? PS_ADDR : PS_IDLE;
          PS_ADDR: begin
            addr_q <= byte_data;
            st_q   <= is_wr_q ? PS_DATA : PS_IDLE;
          end
          PS_DATA: st_q <= PS_IDLE;
          default: st_q <= PS_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import cfgrate_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int DIV_W  = 8,
  localparam int MASK_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [BYTE_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_stb,
  input  logic [BYTE_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [BYTE_W-1:0] rd_data,
  output logic [MASK_W-1:0] mask,
  output logic [DIV_W-1:0]  div_n,
  output logic              base_sel
);
  logic [BYTE_W-1:0] mask_lo_q, mask_hi_q;
  logic [BYTE_W-1:0] rd_mux;

  assign mask = {mask_hi_q, mask_lo_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_lo_q <= '1;
      mask_hi_q <= '1;
      div_n     <= '0;
      base_sel  <= 1'b0;
    end else if (wr_stb) begin
      case (wr_addr)
        ADR_MASK_LO: mask_lo_q <= wr_data;
        ADR_MASK_HI: mask_hi_q <= wr_data;
        ADR_DIV:     div_n     <= DIV_W'(wr_data);
        ADR_BASE:    base_sel  <= wr_data[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_addr)
      ADR_MASK_LO: rd_mux = mask_lo_q;
      ADR_MASK_HI: rd_mux = mask_hi_q;
      ADR_DIV:     rd_mux = BYTE_W'(div_n);
      ADR_BASE:    rd_mux = BYTE_W'(base_sel);
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_stb;
      if (rd_stb) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/rate_div.sv
module rate_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_a,
  input  logic             tick_b,
  input  logic             sel_req,
  input  logic [DIV_W-1:0] n_req,
  output logic             stb
);
  logic             sel_q;
  logic [DIV_W-1:0] n_q;
  logic [DIV_W-1:0] cnt_q;
  logic             tick;

  assign tick = sel_q ? tick_b : tick_a;

  // settings are shadowed and reloaded only at a period boundary
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b0;
      n_q   <= '0;
      cnt_q <= '0;
      stb   <= 1'b0;
    end else begin
      stb <= 1'b0;
      if (tick) begin
        if (cnt_q == n_q) begin
          stb   <= 1'b1;
          cnt_q <= '0;
          n_q   <= n_req;
          sel_q <= sel_req;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cfg_rate_ctrl.sv
module cfg_rate_ctrl #(
  parameter int DIV_W = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        byte_valid,
  input  logic [7:0]  byte_data,
  input  logic        frame_start,
  input  logic        base_en_a,
  input  logic        base_en_b,
  output logic        rd_valid,
  output logic [7:0]  rd_data,
  output logic [15:0] chan_mask,
  output logic        sample_stb
);
  localparam int BYTE_W = 8;

  logic              wr_stb, rd_stb, base_sel;
  logic [BYTE_W-1:0] wr_addr, wr_data, rd_addr;
  logic [DIV_W-1:0]  div_n;

  cmd_parser #(.BYTE_W(BYTE_W)) i_parse (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
    .frame_start(frame_start), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_stb(rd_stb), .rd_addr(rd_addr)
  );

  cfg_regs #(.BYTE_W(BYTE_W), .DIV_W(DIV_W)) i_regs (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_stb(rd_stb), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .mask(chan_mask),
    .div_n(div_n), .base_sel(base_sel)
  );

  rate_div #(.DIV_W(DIV_W)) i_div (
    .clk(clk), .rst(rst), .tick_a(base_en_a), .tick_b(base_en_b),
    .sel_req(base_sel), .n_req(div_n), .stb(sample_stb)
  );
endmodule

// File: rtl/cfg_rate_ctrl_chk.sv
module cfg_rate_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        byte_valid,
  input logic        base_en_a,
  input logic        base_en_b,
  input logic        rd_valid,
  input logic [15:0] chan_mask,
  input logic        sample_stb
);
  a_r3_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (chan_mask == 16'hFFFF && !rd_valid && !sample_stb));

  a_r1_mask_needs_byte: assert property (@(posedge clk) disable iff (rst)
    !$past(byte_valid) |-> $stable(chan_mask));

  a_r2_resp_after_byte: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(byte_valid));

  a_r2_single_resp: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  a_r4_stb_on_tick: assert property (@(posedge clk) disable iff (rst)
    sample_stb |-> $past(base_en_a || base_en_b));
endmodule

bind cfg_rate_ctrl cfg_rate_ctrl_chk i_chk (
  .clk(clk), .rst(rst), .byte_valid(byte_valid), .base_en_a(base_en_a),
  .base_en_b(base_en_b), .rd_valid(rd_valid), .chan_mask(chan_mask),
  .sample_stb(sample_stb)
);

// File: tb/test_cfg_rate_ctrl.sv
module test_cfg_rate_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        frame_start = 1'b0;
  logic        base_en_a = 1'b1;
  logic        base_en_b = 1'b0;
  logic        b_toggle = 1'b0;
  logic        rd_valid, sample_stb;
  logic [7:0]  rd_data;
  logic [15:0] chan_mask;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (b_toggle) base_en_b <= ~base_en_b; else base_en_b <= 1'b0;

  cfg_rate_ctrl i_cfg_rate_ctrl (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
    .frame_start(frame_start), .base_en_a(base_en_a), .base_en_b(base_en_b),
    .rd_valid(rd_valid), .rd_data(rd_data), .chan_mask(chan_mask),
    .sample_stb(sample_stb)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected read bytes as responses appear
  always @(negedge clk) if (!rst && rd_valid) begin
    if (exp_q.size() == 0) check("R6 unexpected response", 1, 0);
    else begin
      automatic logic [7:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      check(t, rd_data, e);
    end
  end

  task automatic put(input logic [7:0] b, input logic fs);
    byte_valid = 1'b1; byte_data = b; frame_start = fs;
    @(negedge clk);
    byte_valid = 1'b0; frame_start = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    put(8'h80, 1); put(8'h01, 0); put(a, 0); put(d, 0);
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    put(8'h81, 1); put(8'h01, 0); put(a, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_stb(output int t);
    do @(negedge clk); while (!sample_stb);
    t = cyc;
  endtask

  task automatic period(input string req, input int exp);
    int t0, t1;
    wait_stb(t0); wait_stb(t0); wait_stb(t1);
    check(req, t1 - t0, exp);
  endtask

  initial begin
    int ta, tb, tc;
    repeat (4) @(negedge clk);
    check("R3 mask reset", chan_mask, 16'hFFFF);
    check("R3 rd_valid reset", rd_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    rd(8'h04, 8'h00, "R3 divider reset");
    rd(8'h0A, 8'h00, "R3 select reset");
    period("R3 R4 period N=0", 1);

    wr(8'h02, 8'h07);
    check("R1 mask low", chan_mask, 16'hFF07);
    wr(8'h03, 8'h00);
    check("R1 mask high", chan_mask, 16'h0007);
    rd(8'h02, 8'h07, "R2 read mask low");
    rd(8'h03, 8'h00, "R2 read mask high");

    put(8'h82, 1); put(8'h01, 0); put(8'h02, 0); put(8'h55, 0);
    check("R6 bad opcode", chan_mask, 16'h0007);
    put(8'h80, 1); put(8'h02, 0); put(8'h03, 0); put(8'hAA, 0);
    check("R6 bad key", chan_mask, 16'h0007);
    put(8'h55, 1); put(8'h80, 0); put(8'h01, 0); put(8'h03, 0); put(8'hAA, 0);
    put(8'h81, 0); put(8'h01, 0); put(8'h02, 0);
    repeat (2) @(negedge clk);
    check("R6 stray bytes", chan_mask, 16'h0007);
    check("R6 no response", exp_q.size(), 0);

    rd(8'h05, 8'h00, "R8 unimplemented read");
    wr(8'h05, 8'h33);
    check("R8 ignored write mask", chan_mask, 16'h0007);
    rd(8'h04, 8'h00, "R8 ignored write div");
    rd(8'h0A, 8'h00, "R8 ignored write sel");

    put(8'h80, 1); put(8'h01, 0); put(8'h02, 0);
    rd(8'h02, 8'h07, "R7 restart read");
    check("R7 no write", chan_mask, 16'h0007);

    wr(8'h04, 8'h03);
    rd(8'h04, 8'h03, "R4 read divider");
    period("R4 period N=3", 4);

    b_toggle = 1'b1;
    wr(8'h04, 8'h01);
    wr(8'h0A, 8'hFF);
    rd(8'h0A, 8'h01, "R5 select bit0 only");
    period("R5 base b N=1", 4);
    wr(8'h0A, 8'h00);
    period("R5 base a N=1", 2);
    b_toggle = 1'b0;

    wr(8'h04, 8'h09);
    wait_stb(ta); wait_stb(ta); wait_stb(ta);
    wait_stb(ta);
    wr(8'h04, 8'h02);
    wait_stb(tb);
    wait_stb(tc);
    check("R9 old period completes", tb - ta, 10);
    check("R9 new period", tc - tb, 3);

    repeat (4) @(negedge clk);
    check("R2 all responses seen", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule